// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the write side of a byte-wide parallel NOR flash model. Each bus write reaches it as one address and one data byte, qualified by a single-cycle strobe. It parses these writes against the flash command grammar. A two-write unlock prefix is followed by a command byte. Some operations chain two prefixed sequences. A few short commands need no prefix. Several protection command sets are modal: once one is entered, only a dedicated two-write exit leaves it.

The decoder holds the current device mode and emits a one-cycle operation-start pulse for erase start, suspend and resume. The pulse carries the operation kind and the sector concerned. An external erase engine reports completion on `op_done`. A combinational read port returns identification and per-sector protection bytes while autoselect is active. Every write strobe is accepted; there is no back-pressure on the write or read side.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read) and `op_start` is low.
- R2: The writes AAh at AAAh, then 55h at 555h, then 90h at AAAh select autoselect (mode 1). A single write of F0h at any address, with no sequence in progress, returns autoselect, CFI or array read to array read (mode 0).
- R3: `rd_data` depends on the low 16 bits of `rd_addr` as follows, in autoselect only: 0000h gives 01h, 0002h gives 7Eh, 0004h gives 01h if `prot_mask` bit `rd_addr[19:16]` is set and 00h if it is clear. Every other offset returns 00h, and every mode other than autoselect returns 00h.
- R4: A single write of 98h at 00AAh selects CFI query (mode 2), from array read or autoselect only. In any other mode it has no effect.
- R5: Prefix, 80h at AAAh, prefix, then 10h at AAAh starts a chip erase: `op_kind`=0, `op_sector`=0. Prefix, 80h at AAAh, prefix, then 30h at any address starts a sector erase: `op_kind`=1, `op_sector`=`wr_addr[19:16]`. In both cases `mode` becomes 3 and `op_start` is high for the cycle after the final write.
- R6: A write of B0h while a sector erase runs (mode 3) suspends it. `mode` becomes 4, and a pulse goes out with `op_kind`=2 and the erasing sector. B0h during a chip erase is ignored.
- R7: A write of 30h in mode 4 resumes the erase. `mode` becomes 3, and a pulse goes out with `op_kind`=3 and the erasing sector.
- R8: `op_done` in mode 3 returns the mode to 0. In any other mode it is ignored.
- R9: Prefix, then one of the following bytes at AAAh, enters a command-set mode: 88h gives 5 (secure sector), 40h gives 6 (lock register), 60h gives 7 (password), 50h gives 8 (global freeze), E0h gives 9 (volatile protection).
- R10: A command-set mode is left only by 90h then 00h, at any address, which gives mode 0. Other writes, F0h included, leave the mode unchanged. A 90h followed by any byte other than 00h is discarded.
- R11: During unlock and command writes, `wr_addr[19:16]` is ignored. The exception is a sector erase, which takes its sector from these bits.
- R12: A write that breaks an expected sequence discards the partial sequence. The mode is unchanged and no pulse is produced. This includes a wrong address for a prefix byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 20 | Write byte address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Erase engine reports completion |
| rd_addr | input | 20 | Autoselect read address |
| prot_mask | input | 16 | Per-sector protection status, 1 = protected |
| mode | output | 4 | Current device mode code |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 2 | 0 chip erase, 1 sector erase, 2 suspend, 3 resume |
| op_sector | output | 4 | Sector carried with the pulse |
| rd_data | output | 8 | Autoselect read data |

## Verification
The assertions check several properties on every cycle. A pulse is always caused by a write. A mode change always follows a write or a completion. Suspend is reachable only from a running erase, and erase only from array read or suspend. Every command-set mode exits to array read, and read data stays zero outside autoselect. Only the bench's scenarios can show the rest: that each exact byte and address pattern reaches the right mode, that chip erase cannot be suspended, that broken and high-address sequences behave as required, and that identification bytes follow the protection mask.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    M_READ    = 4'd0,
    M_AUTOSEL = 4'd1,
    M_CFI     = 4'd2,
    M_ERASE   = 4'd3,
    M_SUSP    = 4'd4,
    M_SECURE  = 4'd5,
    M_LOCK    = 4'd6,
    M_PWD     = 4'd7,
    M_FREEZE  = 4'd8,
    M_VPROT   = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    OP_CHIP   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_SUSP   = 2'd2,
    OP_RESUME = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_E1, S_E2, S_E3, S_X1
  } step_e;

  localparam logic [7:0] MFR_CODE = 8'h01;
  localparam logic [7:0] DEV_CODE = 8'h7E;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_AW = 16,
  localparam int SECT_W = ADDR_W - CMD_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  output mode_e             mode,
  output logic              op_start,
  output op_e               op_kind,
  output logic [SECT_W-1:0] op_sector
);
  localparam logic [CMD_AW-1:0] A_AAA = CMD_AW'('hAAA);
  localparam logic [CMD_AW-1:0] A_555 = CMD_AW'('h555);
  localparam logic [CMD_AW-1:0] A_0AA = CMD_AW'('hAA);

  step_e step;
  logic  erase_is_sector;

  logic [CMD_AW-1:0] cmd_a;
  logic at_aaa, at_555, is_f0, is_cfi, is_aa_pfx, is_55_pfx;

  always_comb begin
    cmd_a     = wr_addr[CMD_AW-1:0];
    at_aaa    = (cmd_a == A_AAA);
    at_555    = (cmd_a == A_555);
    is_f0     = (wr_data == 8'hF0);
    is_cfi    = (wr_data == 8'h98) && (cmd_a == A_0AA);
    is_aa_pfx = (wr_data == 8'hAA) && at_aaa;
    is_55_pfx = (wr_data == 8'h55) && at_555;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode            <= M_READ;
      step            <= S_IDLE;
      op_start        <= 1'b0;
      op_kind         <= OP_CHIP;
      op_sector       <= '0;
      erase_is_sector <= 1'b0;
    end else begin
      op_start <= 1'b0;
      if (op_done && mode == M_ERASE) begin
        mode <= M_READ;
        step <= S_IDLE;
      end else if (wr_en) begin
        step <= S_IDLE;
        unique case (step)
          S_IDLE: begin
            unique case (mode)
              M_READ: begin
                if (is_cfi) mode <= M_CFI;
                else if (is_aa_pfx) step <= S_U1;
              end
              M_AUTOSEL: begin
                if (is_f0) mode <= M_READ;
                else if (is_cfi) mode <= M_CFI;
              end
              M_CFI: if (is_f0) mode <= M_READ;
              M_ERASE: begin
                if (wr_data == 8'hB0 && erase_is_sector) begin
                  mode     <= M_SUSP;
                  op_start <= 1'b1;
                  op_kind  <= OP_SUSP;
                end
              end
              M_SUSP: begin
                if (wr_data == 8'h30) begin
                  mode     <= M_ERASE;
                  op_start <= 1'b1;
                  op_kind  <= OP_RESUME;
                end
              end
              default: if (wr_data == 8'h90) step <= S_X1;
            endcase
          end
          S_U1: if (is_55_pfx) step <= S_U2;
          S_U2: begin
            if (at_aaa) begin
              case (wr_data)
                8'h90: mode <= M_AUTOSEL;
                8'h80: step <= S_E1;
                8'h88: mode <= M_SECURE;
                8'h40: mode <= M_LOCK;
                8'h60: mode <= M_PWD;
                8'h50: mode <= M_FREEZE;
                8'hE0: mode <= M_VPROT;
                default: ;
              endcase
            end
          end
          S_E1: if (is_aa_pfx) step <= S_E2;
          S_E2: if (is_55_pfx) step <= S_E3;
          S_E3: begin
            if (wr_data == 8'h10 && at_aaa) begin
              mode            <= M_ERASE;
              op_start        <= 1'b1;
              op_kind         <= OP_CHIP;
              op_sector       <= '0;
              erase_is_sector <= 1'b0;
            end else if (wr_data == 8'h30) begin
              mode            <= M_ERASE;
              op_start        <= 1'b1;
              op_kind         <= OP_SECTOR;
              op_sector       <= wr_addr[ADDR_W-1:CMD_AW];
              erase_is_sector <= 1'b1;
            end
          end
          S_X1: if (wr_data == 8'h00) mode <= M_READ;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_id_read.sv
module flash_id_read
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_AW = 16,
  localparam int NSECT = 1 << (ADDR_W - CMD_AW)
) (
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  prot_mask,
  output logic [7:0]        rd_data
);
  logic [CMD_AW-1:0] off;
  logic              prot_bit;

  always_comb begin
    off      = rd_addr[CMD_AW-1:0];
    prot_bit = prot_mask[rd_addr[ADDR_W-1:CMD_AW]];
    rd_data  = 8'h00;
    if (mode == M_AUTOSEL) begin
      if (off == CMD_AW'('h0))      rd_data = MFR_CODE;
      else if (off == CMD_AW'('h2)) rd_data = DEV_CODE;
      else if (off == CMD_AW'('h4)) rd_data = {7'b0, prot_bit};
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMD_AW = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [7:0]                            wr_data,
  input  logic                                  op_done,
  input  logic [ADDR_W-1:0]                     rd_addr,
  input  logic [(1 << (ADDR_W - CMD_AW))-1:0]   prot_mask,
  output logic [3:0]                            mode,
  output logic                                  op_start,
  output logic [1:0]                            op_kind,
  output logic [ADDR_W-CMD_AW-1:0]              op_sector,
  output logic [7:0]                            rd_data
);
  mode_e mode_q;
  op_e   kind_q;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .op_done   (op_done),
    .mode      (mode_q),
    .op_start  (op_start),
    .op_kind   (kind_q),
    .op_sector (op_sector)
  );

  flash_id_read #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_id (
    .mode      (mode_q),
    .rd_addr   (rd_addr),
    .prot_mask (prot_mask),
    .rd_data   (rd_data)
  );

  assign mode    = mode_q;
  assign op_kind = kind_q;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       op_done,
  input logic [3:0] mode,
  input logic       op_start,
  input logic [1:0] op_kind,
  input logic [7:0] rd_data
);
  // R5 R6 R7: every pulse follows a write
  a_r5_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wr_en));

  // R12 R8: mode moves only after a write or a completion
  a_r12_mode_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> ($past(wr_en) || $past(op_done)));

  // R3: read data silent outside autoselect
  a_r3_quiet_outside_id: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 4'd1) |-> (rd_data == 8'h00));

  // R6: suspend entered only from running erase, with a suspend pulse
  a_r6_suspend_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd4 && $past(mode) != 4'd4) |-> ($past(mode) == 4'd3 && op_start && op_kind == 2'd2));

  // R5 R7: erase entered only from array read or suspend
  a_r7_erase_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd3 && $past(mode) != 4'd3) |-> ($past(mode) == 4'd0 || $past(mode) == 4'd4));

  // R10: command-set modes exit only to array read
  a_r10_set_exit_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) >= 4'd5 && mode != $past(mode)) |-> (mode == 4'd0));
endmodule

bind flash_cmd_decoder flash_cmd_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .op_done  (op_done),
  .mode     (mode),
  .op_start (op_start),
  .op_kind  (op_kind),
  .rd_data  (rd_data)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        op_done = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [15:0] prot_mask = 16'h0020;
  logic [3:0]  mode;
  logic        op_start;
  logic [1:0]  op_kind;
  logic [3:0]  op_sector;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .rd_addr(rd_addr),
    .prot_mask(prot_mask), .mode(mode), .op_start(op_start),
    .op_kind(op_kind), .op_sector(op_sector), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        wr;
    logic        done;
    logic [19:0] addr;
    logic [7:0]  data;
    logic [3:0]  emode;
    logic        eop;
    logic [1:0]  ekind;
    logic [3:0]  esect;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VEC [NV] = '{
    // R2 autoselect entry and F0 exit
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd2},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd2},
    '{1'b1,1'b0,20'h00AAA,8'h90,4'd1,1'b0,2'd0,4'd0,4'd2},
    '{1'b1,1'b0,20'h00123,8'hF0,4'd0,1'b0,2'd0,4'd0,4'd2},
    // R4 CFI from read
    '{1'b1,1'b0,20'h000AA,8'h98,4'd2,1'b0,2'd0,4'd0,4'd4},
    '{1'b1,1'b0,20'h00000,8'hF0,4'd0,1'b0,2'd0,4'd0,4'd2},
    // R5 sector erase on sector 3
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00AAA,8'h80,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h30000,8'h30,4'd3,1'b1,2'd1,4'd3,4'd5},
    // R6 suspend, R4 CFI ignored, R7 resume, R8 done
    '{1'b1,1'b0,20'h00000,8'hB0,4'd4,1'b1,2'd2,4'd3,4'd6},
    '{1'b1,1'b0,20'h000AA,8'h98,4'd4,1'b0,2'd0,4'd0,4'd4},
    '{1'b1,1'b0,20'h00000,8'h30,4'd3,1'b1,2'd3,4'd3,4'd7},
    '{1'b0,1'b1,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd8},
    // R5 chip erase, R6 B0 ignored, R8 done
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00AAA,8'h80,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00AAA,8'h10,4'd3,1'b1,2'd0,4'd0,4'd5},
    '{1'b1,1'b0,20'h00000,8'hB0,4'd3,1'b0,2'd0,4'd0,4'd6},
    '{1'b0,1'b1,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd8},
    // R9 lock register set, R10 F0 ignored and exit
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00AAA,8'h40,4'd6,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00000,8'hF0,4'd6,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h90,4'd6,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd10},
    // R12 prefix broken by wrong address
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd12},
    '{1'b1,1'b0,20'h00554,8'h55,4'd0,1'b0,2'd0,4'd0,4'd12},
    '{1'b1,1'b0,20'h00AAA,8'h90,4'd0,1'b0,2'd0,4'd0,4'd12},
    // R11 high address bits ignored
    '{1'b1,1'b0,20'hF0AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd11},
    '{1'b1,1'b0,20'h30555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd11},
    '{1'b1,1'b0,20'h50AAA,8'h90,4'd1,1'b0,2'd0,4'd0,4'd11},
    // R4 CFI from autoselect
    '{1'b1,1'b0,20'h000AA,8'h98,4'd2,1'b0,2'd0,4'd0,4'd4},
    '{1'b1,1'b0,20'h00000,8'hF0,4'd0,1'b0,2'd0,4'd0,4'd2},
    // R9 volatile set, R10 broken exit then exit
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00AAA,8'hE0,4'd9,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00000,8'h90,4'd9,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h55,4'd9,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h90,4'd9,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd10},
    // R9 secure sector set
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00AAA,8'h88,4'd5,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00000,8'h90,4'd5,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd10},
    // R9 password set
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00AAA,8'h60,4'd7,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00000,8'h90,4'd7,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd10},
    // R9 global freeze set
    '{1'b1,1'b0,20'h00AAA,8'hAA,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00555,8'h55,4'd0,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00AAA,8'h50,4'd8,1'b0,2'd0,4'd0,4'd9},
    '{1'b1,1'b0,20'h00000,8'h90,4'd8,1'b0,2'd0,4'd0,4'd10},
    '{1'b1,1'b0,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd10},
    // R8 done ignored in read
    '{1'b0,1'b1,20'h00000,8'h00,4'd0,1'b0,2'd0,4'd0,4'd8}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample at next negedge
  task automatic step(input logic w, input logic d, input logic [19:0] a, input logic [7:0] v);
    wr_en = w; op_done = d; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0;
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] v);
    step(1'b1, 1'b0, a, v);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "mode", int'(mode), 0);
    check("R1", "op_start", int'(op_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "mode after release", int'(mode), 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      step(VEC[i].wr, VEC[i].done, VEC[i].addr, VEC[i].data);
      check(rq, $sformatf("row %0d mode", i), int'(mode), int'(VEC[i].emode));
      check(rq, $sformatf("row %0d op_start", i), int'(op_start), int'(VEC[i].eop));
      if (VEC[i].eop) begin
        check(rq, $sformatf("row %0d op_kind", i), int'(op_kind), int'(VEC[i].ekind));
        check(rq, $sformatf("row %0d op_sector", i), int'(op_sector), int'(VEC[i].esect));
      end
    end

    // R3 reads outside autoselect return zero
    rd_addr = 20'h00000; #1;
    check("R3", "read in array mode", int'(rd_data), 0);
    // R3 autoselect identification bytes
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'h00AAA, 8'h90);
    check("R2", "autoselect entered", int'(mode), 1);
    rd_addr = 20'h00000; #1; check("R3", "manufacturer", int'(rd_data), 8'h01);
    rd_addr = 20'h00002; #1; check("R3", "device byte", int'(rd_data), 8'h7E);
    rd_addr = 20'h50004; #1; check("R3", "sector 5 protected", int'(rd_data), 8'h01);
    rd_addr = 20'h60004; #1; check("R3", "sector 6 open", int'(rd_data), 8'h00);
    rd_addr = 20'h00006; #1; check("R3", "other offset", int'(rd_data), 8'h00);
    prot_mask = 16'h0040;
    rd_addr = 20'h60004; #1; check("R3", "sector 6 now protected", int'(rd_data), 8'h01);
    // R12: prefix inside autoselect is not a command; stays autoselect
    wr(20'h00AAA, 8'hAA);
    check("R12", "autoselect holds", int'(mode), 1);
    wr(20'h00000, 8'hF0);
    check("R2", "F0 leaves autoselect", int'(mode), 0);

    // R12 erase sequence broken at the second prefix
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'h00AAA, 8'h80);
    wr(20'h00AAA, 8'hAA); wr(20'h00AAA, 8'h55);
    wr(20'h10000, 8'h30);
    check("R12", "broken erase no mode change", int'(mode), 0);
    check("R12", "broken erase no pulse", int'(op_start), 0);

    // R1 reset in the middle of an erase
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'h00AAA, 8'h80);
    wr(20'h00AAA, 8'hAA); wr(20'h00555, 8'h55); wr(20'hA0000, 8'h30);
    check("R5", "sector 10 erase", int'(op_sector), 10);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset clears erase", int'(mode), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule